// File: doc/BRIEF.md
# UART Bit-Rate and Character-Time Generator

This block produces the timing skeleton of a serial port. It holds a mode word and two divisors, written through a small write port. It emits a single-cycle bit-rate enable and a character-done pulse that repeats once per full character time. The reference clock is either the input clock or that clock divided by eight. The bit period is the reference period times the clock divisor times one more than the bit divisor.

The mode word is decoded into the character format: data bits, parity on or off, parity sense and stop bits. From these it gives the total number of bit slots in one character. The serialiser, the sampler and the FIFOs sit outside this block and use the tick, the character pulse and the decoded format. Any accepted write restarts all counters, so new timing starts from a clean phase.

Top module: `uabt_timer`

## Requirements
- R1: After reset the clock divisor is 15, the bit divisor is 0 and the mode word is 0. The default format is therefore 8 data bits, even parity, 2 stop bits, 12 bit slots per character, and the first bit tick comes 15 cycles after reset is released.
- R2: Mode bits [2:1] set the character length: 2'b11 gives 6 data bits, 2'b10 gives 7, and any other value gives 8 (`data_bits`).
- R3: Mode bits [5:3] set parity: 3'b000 is even (`par_en`=1, `par_odd`=0), 3'b001 is odd (`par_en`=1, `par_odd`=1), and any other value means no parity (`par_en`=0, `par_odd`=0).
- R4: Mode bits [7:6] set the stop length: 2'b11 gives 1 stop bit, any other value gives 2 (`stop_bits`).
- R5: `frame_bits` equals 1 + data bits + (1 if parity is on) + stop bits.
- R6: With mode bit 0 clear, `baud_tick` pulses for one cycle every P = clock divisor × (bit divisor + 1) cycles. The first pulse is in cycle P-1 counted from 0 at the first cycle after the last restart.
- R7: With mode bit 0 set, the period is 8 × clock divisor × (bit divisor + 1) cycles, with the same phase rule as R6.
- R8: `char_done` pulses together with every `frame_bits`-th `baud_tick` after a restart, and never without `baud_tick`.
- R9: A clock divisor of 0 stops both pulses until a nonzero divisor is written.
- R10: A write with `wr_sel` 0 (mode, `wr_data[7:0]`), 1 (clock divisor) or 2 (bit divisor, `wr_data[7:0]`) suppresses both pulses in its own cycle. The new value applies from the next cycle, and all counters restart there.
- R11: A write with `wr_sel` 3 has no effect: no register changes and the pulse sequence continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 mode, 1 clock divisor, 2 bit divisor, 3 none |
| wr_data | input | 16 | Write value |
| baud_tick | output | 1 | One-cycle bit-rate enable |
| char_done | output | 1 | One-cycle pulse at the end of each character time |
| data_bits | output | 4 | Decoded data bit count |
| par_en | output | 1 | Parity enabled |
| par_odd | output | 1 | Parity is odd |
| stop_bits | output | 2 | Decoded stop bit count |
| frame_bits | output | 4 | Total bit slots per character |

## Verification
A configuration write and a due bit tick (often with a character end) can fall in the same cycle. The write must win: both pulses are held low in that cycle, and the count restarts the cycle after. This collision is forced by setting a period of one cycle, so that every cycle carries a tick, and then writing the bit divisor repeatedly. The per-cycle reference model expects no pulse in each write cycle and a tick in every other cycle. It is also driven by writes dropped at arbitrary phases of longer periods.

// File: rtl/uabt_pkg.sv
package uabt_pkg;

    localparam int MODE_W    = 8;
    localparam int PRESCALE  = 8;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_CDIV = 2'd1,
        SEL_BDIV = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    // Field positions are behaviour: external software composes this word.
    typedef struct packed {
        logic [1:0] stop_code;
        logic [2:0] par_code;
        logic [1:0] len_code;
        logic       ref_div8;
    } mode_t;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop_bits;
        logic [3:0] frame_bits;
    } frame_fmt_t;

    function automatic logic [3:0] len_of(input logic [1:0] code);
        case (code)
            2'b11:   return 4'd6;
            2'b10:   return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

    function automatic frame_fmt_t decode_mode(input mode_t m);
        frame_fmt_t f;
        f.data_bits  = len_of(m.len_code);
        f.par_en     = (m.par_code == 3'b000) || (m.par_code == 3'b001);
        f.par_odd    = (m.par_code == 3'b001);
        f.stop_bits  = (m.stop_code == 2'b11) ? 2'd1 : 2'd2;
        f.frame_bits = 4'd1 + f.data_bits + {3'd0, f.par_en} + {2'd0, f.stop_bits};
        return f;
    endfunction

endpackage

// File: rtl/uabt_prescale.sv
module uabt_prescale #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic div_sel,
    output logic ref_en
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (div_sel) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign ref_en = div_sel ? (cnt_q == LAST) : 1'b1;
endmodule

// File: rtl/uabt_cnt_stage.sv
module uabt_cnt_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;
    logic         at_lim;

    assign at_lim = (cnt_q == limit);
    assign last   = en && at_lim;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uabt_fmt_decode.sv
module uabt_fmt_decode
    import uabt_pkg::*;
(
    input  mode_t      mode,
    output frame_fmt_t fmt
);
    assign fmt = decode_mode(mode);
endmodule

// File: rtl/uabt_timer.sv
module uabt_timer
    import uabt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CDIV_W   = 16,
    parameter int BDIV_W   = 8,
    parameter int CDIV_RST = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              baud_tick,
    output logic              char_done,
    output logic [3:0]        data_bits,
    output logic              par_en,
    output logic              par_odd,
    output logic [1:0]        stop_bits,
    output logic [3:0]        frame_bits
);
    localparam int FRM_W = 4;

    mode_t             mode_q;
    logic [CDIV_W-1:0] cdiv_q;
    logic [BDIV_W-1:0] bdiv_q;
    frame_fmt_t        fmt;
    wr_sel_e           sel;
    logic              restart;
    logic              ref_div8;
    logic              ref_en;
    logic              cdiv_nz;
    logic              samp_tick;
    logic              baud_raw;

    assign sel      = wr_sel_e'(wr_sel);
    assign restart  = wr_en && (sel != SEL_NONE);
    assign ref_div8 = mode_q.ref_div8;
    assign cdiv_nz  = (cdiv_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cdiv_q <= CDIV_W'(CDIV_RST);
            bdiv_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: mode_q <= mode_t'(wr_data[MODE_W-1:0]);
                SEL_CDIV: cdiv_q <= wr_data[CDIV_W-1:0];
                SEL_BDIV: bdiv_q <= wr_data[BDIV_W-1:0];
                default:  ;
            endcase
        end
    end

    uabt_prescale #(.RATIO(PRESCALE)) u_pre (
        .clk(clk), .rst(rst), .clr(restart),
        .div_sel(ref_div8), .ref_en(ref_en)
    );

    uabt_cnt_stage #(.W(CDIV_W)) u_cdiv (
        .clk(clk), .rst(rst), .clr(restart),
        .en(ref_en && cdiv_nz), .limit(cdiv_q - 1'b1), .last(samp_tick)
    );

    uabt_cnt_stage #(.W(BDIV_W)) u_bdiv (
        .clk(clk), .rst(rst), .clr(restart),
        .en(samp_tick), .limit(bdiv_q), .last(baud_raw)
    );

    assign baud_tick = baud_raw && !restart;

    uabt_cnt_stage #(.W(FRM_W)) u_frm (
        .clk(clk), .rst(rst), .clr(restart),
        .en(baud_tick), .limit(fmt.frame_bits - 1'b1), .last(char_done)
    );

    uabt_fmt_decode u_dec (.mode(mode_q), .fmt(fmt));

    assign data_bits  = fmt.data_bits;
    assign par_en     = fmt.par_en;
    assign par_odd    = fmt.par_odd;
    assign stop_bits  = fmt.stop_bits;
    assign frame_bits = fmt.frame_bits;
endmodule

// File: rtl/uabt_timer_chk.sv
module uabt_timer_chk #(
    parameter int CDIV_W   = 16,
    parameter int CDIV_RST = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              baud_tick,
    input logic              char_done,
    input logic [CDIV_W-1:0] cdiv_q,
    input logic              ref_div8
);
    AST_RESET_DIV: assert property (@(posedge clk) rst |=> (cdiv_q == CDIV_W'(CDIV_RST))); // R1
    AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (rst)
        (ref_div8 && baud_tick) |=> !baud_tick); // R7
    AST_CHAR_ON_BAUD: assert property (@(posedge clk) disable iff (rst)
        char_done |-> baud_tick); // R8
    AST_ZERO_DIV_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cdiv_q == '0) |-> !baud_tick); // R9
    AST_WRITE_GAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != 2'd3) |-> (!baud_tick && !char_done)); // R10
endmodule

bind uabt_timer uabt_timer_chk #(.CDIV_W(CDIV_W), .CDIV_RST(CDIV_RST)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .baud_tick(baud_tick), .char_done(char_done),
    .cdiv_q(cdiv_q), .ref_div8(ref_div8)
);

// File: tb/sim_uabt_timer.sv
module sim_uabt_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        baud_tick, char_done, par_en, par_odd;
    logic [3:0]  data_bits, frame_bits;
    logic [1:0]  stop_bits;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string tick_tag = "R6";

    // reference model state
    int    m_mode = 0;
    int    m_cdiv = 15;
    int    m_bdiv = 0;
    longint t = 0;

    always #5 clk = ~clk;

    uabt_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .baud_tick(baud_tick), .char_done(char_done), .data_bits(data_bits),
        .par_en(par_en), .par_odd(par_odd), .stop_bits(stop_bits), .frame_bits(frame_bits)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0d mode=%0h cdiv=%0d bdiv=%0d)",
                     tag, act, exp, t, m_mode, m_cdiv, m_bdiv);
        end
    endtask

    function automatic int exp_data();
        int c = (m_mode >> 1) & 3;
        if (c == 3) return 6;
        if (c == 2) return 7;
        return 8;
    endfunction
    function automatic int exp_par_en();
        int p = (m_mode >> 3) & 7;
        return (p <= 1) ? 1 : 0;
    endfunction
    function automatic int exp_odd();
        return (((m_mode >> 3) & 7) == 1) ? 1 : 0;
    endfunction
    function automatic int exp_stop();
        return (((m_mode >> 6) & 3) == 3) ? 1 : 2;
    endfunction
    function automatic int exp_frame();
        return 1 + exp_data() + exp_par_en() + exp_stop();
    endfunction

    task automatic cyc(input bit we, input int sel, input int d);
        bit hit;
        longint p;
        int exp_b, exp_c;
        wr_en = we; wr_sel = 2'(sel); wr_data = 16'(d);
        #1;
        hit = we && (sel != 3);
        p = longint'((m_mode & 1) ? 8 : 1) * m_cdiv * (m_bdiv + 1);
        exp_b = (!hit && m_cdiv != 0 && ((t + 1) % p == 0)) ? 1 : 0;
        exp_c = (exp_b == 1 && ((t + 1) % (p * exp_frame()) == 0)) ? 1 : 0;
        chk(tick_tag, baud_tick, exp_b);
        chk("R8 char_done", char_done, exp_c);
        chk("R2 data_bits", data_bits, exp_data());
        chk("R3 par_en", par_en, exp_par_en());
        chk("R3 par_odd", par_odd, exp_odd());
        chk("R4 stop_bits", stop_bits, exp_stop());
        chk("R5 frame_bits", frame_bits, exp_frame());
        @(posedge clk);
        if (hit) begin
            if (sel == 0) m_mode = d & 8'hFF;
            if (sel == 1) m_cdiv = d & 16'hFFFF;
            if (sel == 2) m_bdiv = d & 8'hFF;
            t = 0;
        end else begin
            t++;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: default format and divider after reset
        chk("R1 frame_bits default", frame_bits, 12);
        chk("R1 data_bits default", data_bits, 8);
        tick_tag = "R1/R6 baud_tick default";
        idle(200);

        // R6: divider and format change, odd parity, 6 bits, 1 stop
        tick_tag = "R6 baud_tick";
        cyc(1, 0, 'hCE);
        cyc(1, 1, 3);
        cyc(1, 2, 1);
        idle(150);

        // R7: reference divided by eight, 7 bits, no parity, 2 stop
        tick_tag = "R7 baud_tick div8";
        cyc(1, 0, 'h65);
        cyc(1, 1, 2);
        cyc(1, 2, 0);
        idle(170);

        // R11: select code 3 ignored mid-run
        tick_tag = "R11 baud_tick after ignored write";
        cyc(1, 3, 'h0000);
        idle(20);
        cyc(1, 3, 'hFFFF);
        idle(200);

        // R10: writes colliding with pending ticks
        tick_tag = "R10 baud_tick write collision";
        cyc(1, 0, 'h00);
        cyc(1, 1, 1);
        for (int k = 0; k < 12; k++) begin
            cyc(1, 2, 0);
            idle(2);
        end
        cyc(1, 1, 3);
        for (int k = 0; k < 10; k++) begin
            idle(k + 1);
            cyc(1, 2, k % 3);
        end
        idle(60);

        // R9: zero clock divisor stops ticks
        tick_tag = "R9 baud_tick zero divisor";
        cyc(1, 1, 0);
        idle(100);
        tick_tag = "R6 baud_tick resume";
        cyc(1, 1, 2);
        idle(60);

        // R2-R5: remaining decode combinations
        tick_tag = "R6 baud_tick decode sweep";
        cyc(1, 0, 'h02); idle(30);
        cyc(1, 0, 'h18); idle(30);
        cyc(1, 0, 'h28); idle(30);
        cyc(1, 0, 'h84); idle(30);
        cyc(1, 0, 'hFE); idle(30);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual=not finished expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule